// File: doc/BRIEF.md
# Charge-Redistribution SAR Sequencer

This block runs the digital side of a successive-approximation converter built on a binary-weighted capacitor array. It drives a three-way switch code for every capacitor (sample, reference or ground) and the comparator auto-zero switch. While the converter is idle, the largest capacitor follows the analog input and the comparator is auto-zeroed. A convert pulse traps that charge and starts a search from the most significant bit down to the least significant bit, one bit per clock.

In each trial, the capacitor under test is placed on the reference. The comparator answer decides whether that capacitor stays on the reference or returns to ground. Once the least significant bit is decided, the block registers the result word, clears its busy flag and puts the array back in the sampling configuration. Convert pulses that arrive during a conversion have no effect.

Top module: `sar_cap_sequencer`

## Requirements
- R1: Switch codes are 2 bits per capacitor, with capacitor i at bits [2i+1:2i] of `sw_code_o`: 00 = ground, 01 = reference, 10 = sample. After reset and while idle, capacitor N-1 is at 10, all others are at 00, `azero_o` = 1, `busy_o` = 0 and `result_o` = 0.
- R2: The cycle after a convert pulse is accepted, `busy_o` = 1, `azero_o` = 0 and every capacitor is at ground (00). This is the trap step.
- R3: The cycle after the trap step is the first trial: capacitor N-1 is at reference (01) and all others are at ground.
- R4: During the trial for bit k, capacitors above k hold their decided positions (01 for a kept bit, 00 for a dropped one), capacitor k is at 01, capacitors below k are at 00, `azero_o` stays 0 and no capacitor shows the sample code.
- R5: A comparator input of 1 at the end of a trial keeps that bit at reference (bit = 1), and 0 returns it to ground (bit = 0). With an ideal comparator, the result equals the held input code.
- R6: `busy_o` stays high for exactly N+1 cycles per conversion. When it falls, the array is back in the idle sampling configuration with `azero_o` = 1.
- R7: `result_o` changes only at the end of a conversion, where it takes the decided bits. It holds its value between conversions.
- R8: A convert pulse while `busy_o` = 1 is ignored: it neither restarts nor lengthens the conversion, and it does not start a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Convert pulse, sampled on the clock edge |
| cmp_i | input | 1 | Comparator output, 1 = node above ground |
| sw_code_o | output | 2*N | Per-capacitor switch codes |
| azero_o | output | 1 | Comparator auto-zero switch closed |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | N | Last conversion result |

## Verification
The assertions assume that `cmp_i` is a settled value at every rising edge during trials. They also assume that `start_i` is synchronous to `clk`. The bench models the comparator combinationally from the switch codes the block emits, compared against an input code that is held for the whole conversion. It changes `start_i` and the analog value only at falling edges. Convert pulses injected during busy cycles exercise the ignore rule without breaking these assumptions.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {SW_GND = 2'b00, SW_REF = 2'b01, SW_SMP = 2'b10} sw_code_e;
  typedef enum logic [1:0] {PH_SAMPLE = 2'd0, PH_TRAP = 2'd1, PH_TRIAL = 2'd2} phase_e;

  // code for one capacitor: the top one samples while idle, otherwise a bit maps to ref/gnd
  function automatic sw_code_e cap_code(input phase_e ph, input logic is_top, input logic bit_on);
    if (ph == PH_SAMPLE) return is_top ? SW_SMP : SW_GND;
    return bit_on ? SW_REF : SW_GND;
  endfunction
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int N  = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output phase_e        phase_o,
  output logic [IW-1:0] idx_o,
  output logic          accept_o,
  output logic          seed_o,
  output logic          decide_o,
  output logic          last_o
);
  phase_e        phase_q;
  logic [IW-1:0] idx_q;

  assign accept_o = (phase_q == PH_SAMPLE) && start_i;
  assign seed_o   = (phase_q == PH_TRAP);
  assign decide_o = (phase_q == PH_TRIAL);
  assign last_o   = decide_o && (idx_q == '0);
  assign phase_o  = phase_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SAMPLE;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_SAMPLE: if (start_i) phase_q <= PH_TRAP;
        PH_TRAP: begin
          phase_q <= PH_TRIAL;
          idx_q   <= IW'(N - 1);
        end
        PH_TRIAL: begin
          if (idx_q == '0) phase_q <= PH_SAMPLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        default: phase_q <= PH_SAMPLE;
      endcase
    end
  end

  // R2
  start_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> seed_o);
  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_o && !last_o) |=> (decide_o && idx_o == $past(idx_o) - 1'b1));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_o || (decide_o && !last_o)) |=> (phase_o != PH_SAMPLE) && (phase_o != PH_TRAP || !$past(decide_o)));
endmodule

// File: rtl/sar_seq_bits.sv
module sar_seq_bits #(
  parameter int N  = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          seed_i,
  input  logic          decide_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [N-1:0]  bits_o
);
  logic [N-1:0] bits_q;

  // latch the tested bit from the comparator, then raise the next lower trial bit
  function automatic logic [N-1:0] step_bits(input logic [N-1:0] b, input logic [IW-1:0] k,
                                             input logic c);
    logic [N-1:0] r;
    r    = b;
    r[k] = c;
    if (k != '0) r[k - 1'b1] = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits_q <= '0;
    else if (clear_i)  bits_q <= '0;
    else if (seed_i)   bits_q <= {1'b1, {(N-1){1'b0}}};
    else if (decide_i) bits_q <= step_bits(bits_q, idx_i, cmp_i);
  end

  assign bits_o = bits_q;

  // R5
  cmp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide_i |=> bits_o[$past(idx_i)] == $past(cmp_i));
endmodule

// File: rtl/sar_seq_map.sv
module sar_seq_map
  import sar_seq_pkg::*;
#(
  parameter int N = 12
) (
  input  phase_e         phase_i,
  input  logic [N-1:0]   bits_i,
  output logic [2*N-1:0] codes_o
);
  for (genvar i = 0; i < N; i++) begin : g_cap
    assign codes_o[2*i +: 2] = cap_code(phase_i, (i == N - 1), bits_i[i]);
  end
endmodule

// File: rtl/sar_cap_sequencer.sv
module sar_cap_sequencer
  import sar_seq_pkg::*;
#(
  parameter int N = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           cmp_i,
  output logic [2*N-1:0] sw_code_o,
  output logic           azero_o,
  output logic           busy_o,
  output logic [N-1:0]   result_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [2*N-1:0] FIRST_TRIAL = (2*N)'(SW_REF) << (2*(N-1));
  localparam logic [2*N-1:0] IDLE_CODES  = (2*N)'(SW_SMP) << (2*(N-1));

  phase_e        phase_w;
  logic [IW-1:0] idx_w;
  logic          accept_w, seed_w, decide_w, last_w;
  logic [N-1:0]  bits_w, final_w, result_q;

  sar_seq_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_o(phase_w), .idx_o(idx_w),
    .accept_o(accept_w), .seed_o(seed_w), .decide_o(decide_w), .last_o(last_w));

  sar_seq_bits #(.N(N), .IW(IW)) u_bits (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_w), .seed_i(seed_w), .decide_i(decide_w),
    .idx_i(idx_w), .cmp_i(cmp_i), .bits_o(bits_w));

  sar_seq_map #(.N(N)) u_map (.phase_i(phase_w), .bits_i(bits_w), .codes_o(sw_code_o));

  always_comb begin
    final_w    = bits_w;
    final_w[0] = cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (last_w) result_q <= final_w;
  end

  assign result_o = result_q;
  assign busy_o   = (phase_w != PH_SAMPLE);
  assign azero_o  = (phase_w == PH_SAMPLE);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_w |=> $stable(result_o));
  // R3
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_w |=> sw_code_o == FIRST_TRIAL);
  // R6
  back_to_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> (!busy_o && azero_o && sw_code_o == IDLE_CODES));
  // R2
  trap_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (sw_code_o == '0 && !azero_o));
endmodule

// File: tb/sim_sar_cap_sequencer.sv
`timescale 1ns/1ps
module sim_sar_cap_sequencer;
  localparam int N = 12;
  localparam logic [2*N-1:0] IDLE_CODES  = (2*N)'(2'b10) << (2*(N-1));
  localparam logic [2*N-1:0] FIRST_TRIAL = (2*N)'(2'b01) << (2*(N-1));

  logic clk = 0, rst_n = 0, start_i = 0, cmp_i;
  logic [2*N-1:0] sw_code_o;
  logic azero_o, busy_o;
  logic [N-1:0] result_o;
  int vin_hold = 0;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  sar_cap_sequencer #(.N(N)) u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .sw_code_o(sw_code_o), .azero_o(azero_o), .busy_o(busy_o), .result_o(result_o));

  // analog model: the node stays above ground while the input exceeds the switched-in weight
  function automatic int dac_of(input logic [2*N-1:0] sw);
    int s = 0;
    for (int i = 0; i < N; i++) if (sw[2*i +: 2] == 2'b01) s += (1 << i);
    return s;
  endfunction
  assign cmp_i = (vin_hold >= dac_of(sw_code_o));

  function automatic logic [2*N-1:0] trial_codes(input int v, input int k);
    logic [2*N-1:0] c = '0;
    for (int i = 0; i < N; i++) begin
      if (i > k && v[i]) c[2*i +: 2] = 2'b01;
      if (i == k)        c[2*i +: 2] = 2'b01;
    end
    return c;
  endfunction

  function automatic logic has_sample_code(input logic [2*N-1:0] sw);
    for (int i = 0; i < N; i++) if (sw[2*i +: 2] == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic convert(input int vin, input int inject_at);
    int cycles;
    logic [N-1:0] prev;
    vin_hold = vin;
    start_i  = 1;
    @(negedge clk);
    start_i = 0;
    check(busy_o && !azero_o && sw_code_o == '0, "R2 trap", sw_code_o, 0);
    @(negedge clk);
    check(sw_code_o == FIRST_TRIAL, "R3 first trial", sw_code_o, FIRST_TRIAL);
    cycles = 2;
    forever begin
      check(sw_code_o == trial_codes(vin, N + 1 - cycles) && !azero_o && !has_sample_code(sw_code_o),
            "R4 trial codes", sw_code_o, trial_codes(vin, N + 1 - cycles));
      start_i = (cycles == inject_at);
      @(negedge clk);
      start_i = 0;
      if (!busy_o) break;
      cycles++;
    end
    check(cycles == N + 1, "R6 busy length", cycles, N + 1);
    check(azero_o && sw_code_o == IDLE_CODES, "R6 back to sample", sw_code_o, IDLE_CODES);
    check(result_o == vin[N-1:0], "R5 result", result_o, vin[N-1:0]);
    prev = result_o;
    vin_hold = (vin + 7) & ((1 << N) - 1);
    @(negedge clk);
    @(negedge clk);
    check(!busy_o, "R8 no restart after ignored pulse", busy_o, 0);
    check(result_o == prev, "R7 result held", result_o, prev);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    @(negedge clk);
    check(sw_code_o == IDLE_CODES && azero_o && !busy_o && result_o == '0, "R1 reset state",
          sw_code_o, IDLE_CODES);
    rst_n = 1;
    @(negedge clk);
    check(sw_code_o == IDLE_CODES && azero_o && !busy_o, "R1 idle state", sw_code_o, IDLE_CODES);
    // directed corners; a few with a pulse injected mid-conversion or on the last trial (R8)
    convert(0, 0);
    convert((1 << N) - 1, 4);
    convert(1, N + 1);
    convert(1 << (N - 1), 3);
    convert((1 << (N - 1)) - 1, 0);
    convert(32'h555 & ((1 << N) - 1), 2);
    for (int t = 0; t < 300; t++)
      convert(int'($urandom & ((1 << N) - 1)), int'($urandom_range(0, N + 2)));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule